// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers four interrupt requests and presents one of them at a time to a processor through a request/acknowledge handshake. One request cannot be masked or disabled. The other three have a fixed priority order, and a per-source mask bit can block each one. A global enable flag gates all three. When the processor acknowledges, the controller reports which source won and clears the global enable, so handlers do not nest unless software chooses to allow it.

Software drives a set of strobe-style control inputs. It can write the mask, set or clear the global enable, discard a latched high-priority edge, and mark the end of a handler. Status outputs return the mask, the pending state, the global enable and an in-service marker. To nest interrupts, a handler masks the lower sources and sets the enable again. A higher source can then interrupt it. Leaving a handler takes several steps, all done by software: clear the enable, restore the mask, set the enable, then pulse the return input.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `stat_ie`=0, `stat_mask`=3'b111, `stat_pend`=4'b0000, `in_service`=0 and `irq`=0.
- R2: A rising edge on `nmi_req` is latched, and from the next cycle `irq`=1 and `irq_id`=3. This holds whatever the global enable and the mask are. `irq_valid` always equals `irq`.
- R3: Fixed priority: the non-maskable source (id 3) wins over `req_hi` (id 2), which wins over `req_mid` (id 1), which wins over `req_lo` (id 0).
- R4: A set mask bit blocks its source. Bit 2 masks `req_hi`, bit 1 masks `req_mid` and bit 0 masks `req_lo`. A write with `mask_wr`=1 loads `mask_wdata` at the next clock edge.
- R5: A maskable source can raise `irq` only while the global enable is 1. `ie_set` sets the enable and `ie_clr` clears it. When both are pulsed together, the clear wins.
- R6: When `ack`=1 while `irq`=1, the next cycle shows the global enable cleared and `in_service`=1. The edge latch of the granted source is also cleared. Level-sensitive sources are not cleared by an acknowledge.
- R7: `req_hi` is edge-triggered. Holding it high produces exactly one pending event. `req_mid` and `req_lo` are level-sensitive: their pending bits follow the inputs directly, with no latching.
- R8: A mask write with `clr_hi_pend`=1 clears the `req_hi` pending latch.
- R9: `ret` clears `in_service` only. It leaves the global enable unchanged.
- R10: Inside a handler, software can mask the lower sources and set the enable again. A newly pending higher source then raises `irq` with its own id.
- R11: The `stat_pend` bits are: bit 3 the non-maskable latch, bit 2 the `req_hi` latch, bit 1 the `req_mid` input, and bit 0 the `req_lo` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request, edge-triggered |
| req_hi | input | 1 | Highest maskable request, edge-triggered |
| req_mid | input | 1 | Middle maskable request, level-sensitive |
| req_lo | input | 1 | Lowest maskable request, level-sensitive |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 3 | New mask value {hi, mid, lo} |
| clr_hi_pend | input | 1 | Clears the hi latch when given with `mask_wr` |
| ie_set | input | 1 | Sets the global enable |
| ie_clr | input | 1 | Clears the global enable |
| ret | input | 1 | End of handler |
| ack | input | 1 | Processor acknowledge |
| irq | output | 1 | Interrupt request to the processor |
| irq_valid | output | 1 | Marks `irq_id` as meaningful |
| irq_id | output | 2 | Id of the winning source |
| stat_mask | output | 3 | Current mask |
| stat_pend | output | 4 | Pending status |
| stat_ie | output | 1 | Global enable |
| in_service | output | 1 | Handler-active marker |

## Verification
The assertions check on every cycle that:
- an edge on the non-maskable input is presented on the next cycle;
- a masked source is never granted;
- no maskable request appears while the enable is clear;
- an acknowledge always leaves the enable clear and the in-service marker set;
- a mask write is loaded at the next clock edge.

Only the bench scenarios can show the rest. A sweep over every mask value and request combination confirms that the priority order is correct. Scripted sequences confirm that a held edge input yields exactly one event, and that a masked handler can be pre-empted by a higher source. They also confirm that return leaves the enable untouched.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter logic [2:0] MASK_INIT = 3'b111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nmi_req,
  input  logic       req_hi,
  input  logic       req_mid,
  input  logic       req_lo,
  input  logic       mask_wr,
  input  logic [2:0] mask_wdata,
  input  logic       clr_hi_pend,
  input  logic       ie_set,
  input  logic       ie_clr,
  input  logic       ret,
  input  logic       ack,
  output logic       irq,
  output logic       irq_valid,
  output logic [1:0] irq_id,
  output logic [2:0] stat_mask,
  output logic [3:0] stat_pend,
  output logic       stat_ie,
  output logic       in_service
);

  logic nmi_prev, hi_prev, nmi_p, hi_p, ie, in_svc;
  logic [2:0] mask;
  logic [2:0] cand;
  logic take;

  wire nmi_rise = nmi_req & ~nmi_prev;
  wire hi_rise  = req_hi & ~hi_prev;

  assign cand = {hi_p, req_mid, req_lo} & ~mask;

  always_comb begin
    irq    = 1'b0;
    irq_id = 2'd0;
    if (nmi_p) begin
      irq    = 1'b1;
      irq_id = 2'd3;
    end else if (ie && cand != 3'b000) begin
      irq = 1'b1;
      if (cand[2])      irq_id = 2'd2;
      else if (cand[1]) irq_id = 2'd1;
      else              irq_id = 2'd0;
    end
  end

  assign irq_valid = irq;
  assign take      = ack & irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_prev <= 1'b1;
      hi_prev  <= 1'b1;
      nmi_p    <= 1'b0;
      hi_p     <= 1'b0;
      ie       <= 1'b0;
      in_svc   <= 1'b0;
      mask     <= MASK_INIT;
    end else begin
      nmi_prev <= nmi_req;
      hi_prev  <= req_hi;
      nmi_p    <= nmi_rise | (nmi_p & ~(take && irq_id == 2'd3));
      hi_p     <= hi_rise | (hi_p & ~(take && irq_id == 2'd2) & ~(mask_wr & clr_hi_pend));
      if (mask_wr) mask <= mask_wdata;
      if (take)        ie <= 1'b0;
      else if (ie_clr) ie <= 1'b0;
      else if (ie_set) ie <= 1'b1;
      if (take)     in_svc <= 1'b1;
      else if (ret) in_svc <= 1'b0;
    end
  end

  assign stat_mask  = mask;
  assign stat_pend  = {nmi_p, hi_p, req_mid, req_lo};
  assign stat_ie    = ie;
  assign in_service = in_svc;

  // R2
  nmi_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !nmi_prev) |=> (irq && irq_id == 2'd3));

  // R4
  masked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_id != 2'd3) |-> !stat_mask[irq_id]);

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (stat_mask == $past(mask_wdata)));

  // R5
  ie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_ie && !stat_pend[3]) |-> !irq);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (!stat_ie && in_service));

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_req = 0, req_hi = 0, req_mid = 0, req_lo = 0;
  logic mask_wr = 0, clr_hi_pend = 0, ie_set = 0, ie_clr = 0, ret = 0, ack = 0;
  logic [2:0] mask_wdata = 3'b000;
  logic irq, irq_valid, stat_ie, in_service;
  logic [1:0] irq_id;
  logic [2:0] stat_mask;
  logic [3:0] stat_pend;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .req_hi(req_hi),
    .req_mid(req_mid), .req_lo(req_lo), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .clr_hi_pend(clr_hi_pend), .ie_set(ie_set),
    .ie_clr(ie_clr), .ret(ret), .ack(ack), .irq(irq), .irq_valid(irq_valid),
    .irq_id(irq_id), .stat_mask(stat_mask), .stat_pend(stat_pend),
    .stat_ie(stat_ie), .in_service(in_service));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_mask(logic [2:0] m, logic clr);
    mask_wr = 1; mask_wdata = m; clr_hi_pend = clr; step();
    mask_wr = 0; clr_hi_pend = 0;
  endtask

  task automatic en(logic s, logic c);
    ie_set = s; ie_clr = c; step();
    ie_set = 0; ie_clr = 0;
  endtask

  task automatic pulse_hi();
    req_hi = 1; step(); req_hi = 0; step();
  endtask

  task automatic do_ack();
    ack = 1; step(); ack = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1; step();
    // R1
    chk("R1 ie", stat_ie, 0);
    chk("R1 mask", stat_mask, 7);
    chk("R1 pend", stat_pend, 0);
    chk("R1 irq", irq, 0);
    chk("R1 in_service", in_service, 0);

    // R3 R4 R5 sweep
    for (int m = 0; m < 8; m++) begin
      for (int r = 0; r < 8; r++) begin
        logic [2:0] c;
        int eid;
        req_mid = r[1]; req_lo = r[0];
        wr_mask(m[2:0], 1'b1);
        if (r[2]) pulse_hi();
        en(1'b0, 1'b1);
        chk("R5 disabled irq", irq, 0);
        chk("R11 pend", stat_pend, r);
        en(1'b1, 1'b0);
        c = r[2:0] & ~m[2:0];
        eid = c[2] ? 2 : (c[1] ? 1 : 0);
        chk("R4 irq", irq, (c != 0) ? 1 : 0);
        if (c != 0) chk("R3 id", irq_id, eid);
        chk("R2 valid", irq_valid, irq);
      end
    end
    req_mid = 0; req_lo = 0;
    wr_mask(3'b000, 1'b1);
    chk("R8 hi cleared", stat_pend[2], 0);
    en(1'b1, 1'b1);
    chk("R5 clr wins", stat_ie, 0);

    // R2 NMI ignores enable and mask
    wr_mask(3'b111, 1'b0);
    nmi_req = 1; step();
    chk("R2 irq", irq, 1);
    chk("R2 id", irq_id, 3);
    chk("R11 nmi bit", stat_pend[3], 1);
    do_ack();
    nmi_req = 0;
    chk("R6 nmi cleared", stat_pend[3], 0);
    chk("R6 in_service", in_service, 1);
    chk("R6 ie", stat_ie, 0);
    en(1'b1, 1'b0);
    ret = 1; step(); ret = 0;
    chk("R9 in_service", in_service, 0);
    chk("R9 ie kept", stat_ie, 1);

    // R7 held hi yields one event
    wr_mask(3'b000, 1'b0);
    req_hi = 1; step(); step(); step();
    chk("R7 hi irq", irq_id, 2);
    do_ack();
    en(1'b1, 1'b0);
    step();
    chk("R7 single event", irq, 0);
    chk("R7 latch empty", stat_pend[2], 0);
    req_hi = 0; step();

    // R3 NMI above hi
    pulse_hi();
    nmi_req = 1; step(); nmi_req = 0;
    chk("R3 nmi over hi", irq_id, 3);
    do_ack();
    chk("R6 hi kept", stat_pend[2], 1);
    wr_mask(3'b000, 1'b1);

    // R10 nesting
    en(1'b1, 1'b0);
    req_mid = 1; step();
    chk("R10 mid irq", irq_id, 1);
    do_ack();
    chk("R6 level kept", stat_pend[1], 1);
    pulse_hi();
    chk("R10 no nest", irq, 0);
    wr_mask(3'b011, 1'b0);
    en(1'b1, 1'b0);
    chk("R10 nest irq", irq, 1);
    chk("R10 nest id", irq_id, 2);
    req_mid = 0; step();
    req_lo = 1; step();
    chk("R7 lo level", stat_pend[0], 1);
    req_lo = 0; step();
    chk("R7 lo follows", stat_pend[0], 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule